// File: doc/BRIEF.md
# Decimal Accumulator Processor Core

This block is a compact processor that computes in base ten. A program word holds three BCD digits and one flag bit: the top digit is the operation and the two lower digits name a memory location (00 to 99). The core holds a two-digit program counter, an instruction register, one accumulator and a digit-serial decimal adder/subtractor. It works on a private 100-word memory of 13-bit words. That memory is filled through a preload port while reset is held, and the core then runs the program on its own once reset is released.

Every instruction takes exactly four clock cycles. The cycles are paced by a one-hot phase ring: fetch, operand address, execute, write-back. Values enter the core through an input instruction, which raises a request strobe and stores the word on `in_data` into memory. Values leave through an output instruction, which presents a memory word with a one-cycle valid strobe. A jump leaves a link word in location 99 so that the program can read where it came from. A halt instruction stops the machine until the next reset.

Top module: `dacc_core`

## Requirements
- R1: While `rst` is high, the phase is 4'b0001, `halted`, `out_valid` and `in_req` are low, and the program counter and accumulator are zero. A `pre_we` pulse writes `pre_data` to the BCD address `pre_addr`.
- R2: The phase advances one step per clock in the order 4'b0001, 4'b0010, 4'b0100, 4'b1000, then back to 4'b0001. Exactly one bit is set at any time, so each instruction takes four cycles.
- R3: On the fetch edge, the word at the program counter is loaded into the instruction register. Word bits [11:8] are the operation digit and bits [7:0] are two BCD address digits. The counter then steps in BCD from 99 back to 00.
- R4: Operation 1 copies the whole 13-bit word at the operand address, flag included, into the accumulator on the execute edge. It does not take the word fetched at the next instruction's address.
- R5: Operation 2 adds the three operand digits to the three accumulator digits in decimal, modulo 1000. Bit 12 of the result is the carry out of the hundreds digit. Flag bits of the inputs are ignored.
- R6: Operation 7 subtracts the operand digits from the accumulator digits in decimal. A negative result is kept as its ten's complement with bit 12 set. A non-negative result has bit 12 clear.
- R7: Operation 5 puts the operand word on `out_data`. `out_valid` is high for exactly the one cycle in which the phase is 4'b1000.
- R8: Operation 0 raises `in_req` during its 4'b1000 cycle. The word on `in_data` is written to the operand address at the end of that cycle.
- R9: Operation 6 writes the 13-bit accumulator to the operand address on the write-back edge.
- R10: Operation 8 writes the return address (the address after the jump, as word 0_0XY) to location 99. On the same edge it loads the program counter with the operand address.
- R11: Operation 9 sets `halted` on its execute edge. From then until reset, the phase stays at 4'b1000, and no output, input request or memory write occurs.
- R12: Operation digits 3, 4 and A to F change no register and no memory word. They only take their four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; preload window |
| pre_we | input | 1 | Preload write strobe, honoured while `rst` is high |
| pre_addr | input | 8 | Preload address, two BCD digits |
| pre_data | input | 13 | Preload word |
| in_data | input | 13 | Word taken by the input operation |
| in_req | output | 1 | High in the write-back cycle of an input operation |
| out_data | output | 13 | Word emitted by the output operation |
| out_valid | output | 1 | One-cycle strobe qualifying `out_data` |
| phase | output | 4 | One-hot phase of the sequencer |
| halted | output | 1 | High once a halt has executed |

## Verification
After reset is released, the instruction fetched on edge 4n+1 reaches its accumulator result on edge 4n+3. Its `out_valid` pulse and its `in_req` fall in the cycle that follows, and its store or link write lands on edge 4n+4. A halt is therefore visible 4k-1 cycles after release when it is the k-th instruction. The bench samples every output on the falling edge and numbers these samples from the release. It checks the phase against the ring at every sample, checks the halt on exactly that predicted sample, and collects output words only while `out_valid` is high. It then holds the halted core for twelve more samples to confirm that nothing moves.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int DIGITS   = 3;
    localparam int DIG_W    = 4;
    localparam int MAG_W    = DIGITS * DIG_W;
    localparam int WORD_W   = MAG_W + 1;
    localparam int ADDR_W   = 2 * DIG_W;
    localparam int PHASES   = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] baddr_t;
    typedef logic [PHASES-1:0] phase_t;

    localparam logic [3:0] OP_IN    = 4'h0;
    localparam logic [3:0] OP_LOAD  = 4'h1;
    localparam logic [3:0] OP_ADD   = 4'h2;
    localparam logic [3:0] OP_OUT   = 4'h5;
    localparam logic [3:0] OP_STORE = 4'h6;
    localparam logic [3:0] OP_SUB   = 4'h7;
    localparam logic [3:0] OP_JUMP  = 4'h8;
    localparam logic [3:0] OP_HALT  = 4'h9;

    localparam phase_t PH_FETCH = 4'b0001;
    localparam phase_t PH_ADDR  = 4'b0010;
    localparam phase_t PH_EXEC  = 4'b0100;
    localparam phase_t PH_WB    = 4'b1000;

    // one decimal digit position: returns {carry, digit}
    function automatic logic [4:0] bcd_digit_add(input logic [3:0] x,
                                                 input logic [3:0] y,
                                                 input logic       cin);
        logic [4:0] s;
        logic [4:0] t;
        s = {1'b0, x} + {1'b0, y} + {4'b0, cin};
        t = s + 5'd6;
        return (s > 5'd9) ? {1'b1, t[3:0]} : s;
    endfunction

endpackage

// File: rtl/dacc_phase_ring.sv
module dacc_phase_ring
    import dacc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   hold,
    output phase_t phase
);

    phase_t phase_d, phase_q;

    always_comb begin
        phase_d = phase_q;
        if (!hold) begin
            phase_d = {phase_q[PHASES-2:0], phase_q[PHASES-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase = phase_q;

    // R2
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(phase_q));

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && phase_q == PH_WB) |=> phase_q == PH_FETCH);

    // R2
    phase_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && phase_q == PH_FETCH) |=> phase_q == PH_ADDR);

endmodule

// File: rtl/dacc_bcd_alu.sv
module dacc_bcd_alu
    import dacc_pkg::*;
#(
    parameter int NDIG = DIGITS
)(
    input  logic [NDIG*4-1:0] a,
    input  logic [NDIG*4-1:0] b,
    input  logic              sub,
    output logic [NDIG*4-1:0] y,
    output logic              flag
);

    logic [NDIG:0] carry;
    assign carry[0] = sub;

    for (genvar g = 0; g < NDIG; g++) begin : g_digit
        logic [3:0] b_dig;
        // nine's complement plus incoming one gives ten's complement
        assign b_dig = sub ? (4'd9 - b[g*4 +: 4]) : b[g*4 +: 4];
        assign {carry[g+1], y[g*4 +: 4]} =
            bcd_digit_add(a[g*4 +: 4], b_dig, carry[g]);

        // R5
        always_comb begin
            if (a[g*4 +: 4] <= 4'd9 && b[g*4 +: 4] <= 4'd9) begin
                digit_range_chk: assert (y[g*4 +: 4] <= 4'd9);
            end
        end
    end

    // add: carry out; subtract: borrow is the absence of carry
    assign flag = sub ? ~carry[NDIG] : carry[NDIG];

endmodule

// File: rtl/dacc_word_mem.sv
module dacc_word_mem
    import dacc_pkg::*;
#(
    parameter int WORDS = 100
)(
    input  logic   clk,
    input  logic   we,
    input  baddr_t waddr,
    input  word_t  wdata,
    input  baddr_t raddr,
    output word_t  rdata
);

    localparam int IDX_W = $clog2(WORDS);

    word_t store_q [WORDS];

    logic [ADDR_W-1:0] ridx, widx;
    logic              rok, wok;

    always_comb begin
        ridx = {4'b0, raddr[7:4]} * 8'd10 + {4'b0, raddr[3:0]};
        widx = {4'b0, waddr[7:4]} * 8'd10 + {4'b0, waddr[3:0]};
        rok  = raddr[7:4] <= 4'd9 && raddr[3:0] <= 4'd9 && ridx < 8'(WORDS);
        wok  = waddr[7:4] <= 4'd9 && waddr[3:0] <= 4'd9 && widx < 8'(WORDS);
        rdata = rok ? store_q[ridx[IDX_W-1:0]] : '0;
    end

    always_ff @(posedge clk) begin
        if (we && wok) begin
            store_q[widx[IDX_W-1:0]] <= wdata;
        end
    end

endmodule

// File: rtl/dacc_core.sv
module dacc_core
    import dacc_pkg::*;
#(
    parameter int          MEM_WORDS = 100,
    parameter logic [7:0]  LINK_ADDR = 8'h99
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [WORD_W-1:0] pre_data,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_req,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic [PHASES-1:0] phase,
    output logic              halted
);

    typedef struct packed {
        baddr_t           pc;
        logic [MAG_W-1:0] ir;
        word_t            acc;
        word_t            out_data;
        logic             out_valid;
        logic             halted;
    } core_t;

    core_t st_d, st_q;

    phase_t           ph;
    logic [3:0]       op;
    baddr_t           opnd;
    baddr_t           pc_inc;
    baddr_t           mem_raddr;
    word_t            mem_rdata;
    logic             core_we;
    baddr_t           core_waddr;
    word_t            core_wdata;
    logic [MAG_W-1:0] alu_y;
    logic             alu_flag;

    assign op   = st_q.ir[11:8];
    assign opnd = st_q.ir[7:0];

    dacc_phase_ring u_ring (
        .clk   (clk),
        .rst   (rst),
        .hold  (st_q.halted),
        .phase (ph)
    );

    dacc_bcd_alu #(.NDIG(DIGITS)) u_alu (
        .a    (st_q.acc[MAG_W-1:0]),
        .b    (mem_rdata[MAG_W-1:0]),
        .sub  (op == OP_SUB),
        .y    (alu_y),
        .flag (alu_flag)
    );

    dacc_word_mem #(.WORDS(MEM_WORDS)) u_mem (
        .clk   (clk),
        .we    (rst ? pre_we : core_we),
        .waddr (rst ? pre_addr : core_waddr),
        .wdata (rst ? pre_data : core_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    // BCD program counter step, 99 wraps to 00
    always_comb begin
        if (st_q.pc[3:0] >= 4'd9) begin
            pc_inc[3:0] = 4'd0;
            pc_inc[7:4] = (st_q.pc[7:4] >= 4'd9) ? 4'd0 : st_q.pc[7:4] + 4'd1;
        end else begin
            pc_inc[3:0] = st_q.pc[3:0] + 4'd1;
            pc_inc[7:4] = st_q.pc[7:4];
        end
    end

    always_comb begin
        mem_raddr = (ph == PH_FETCH) ? st_q.pc : opnd;

        st_d           = st_q;
        st_d.out_valid = 1'b0;

        core_we    = 1'b0;
        core_waddr = opnd;
        core_wdata = st_q.acc;
        in_req     = 1'b0;

        if (!st_q.halted) begin
            case (ph)
                PH_FETCH: begin
                    st_d.ir = mem_rdata[MAG_W-1:0];
                    st_d.pc = pc_inc;
                end
                PH_EXEC: begin
                    case (op)
                        OP_LOAD:        st_d.acc = mem_rdata;
                        OP_ADD, OP_SUB: st_d.acc = {alu_flag, alu_y};
                        OP_OUT: begin
                            st_d.out_data  = mem_rdata;
                            st_d.out_valid = 1'b1;
                        end
                        OP_HALT:        st_d.halted = 1'b1;
                        default: ;
                    endcase
                end
                PH_WB: begin
                    case (op)
                        OP_IN: begin
                            in_req     = 1'b1;
                            core_we    = 1'b1;
                            core_wdata = in_data;
                        end
                        OP_STORE: begin
                            core_we = 1'b1;
                        end
                        OP_JUMP: begin
                            core_we    = 1'b1;
                            core_waddr = LINK_ADDR;
                            core_wdata = {1'b0, 4'h0, st_q.pc};
                            st_d.pc    = opnd;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data  = st_q.out_data;
    assign out_valid = st_q.out_valid;
    assign halted    = st_q.halted;
    assign phase     = ph;

    // R7
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7
    out_phase_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> phase == PH_WB);

    // R8
    in_req_next_chk: assert property (@(posedge clk) disable iff (rst)
        in_req |=> phase == PH_FETCH);

    // R3
    pc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!halted && phase == PH_FETCH && st_q.pc == 8'h99) |=> st_q.pc == 8'h00);

    // R11
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(phase) && !out_valid && !in_req));

endmodule

// File: tb/dacc_core_test.sv
`timescale 1ns/1ps
module dacc_core_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pre_we = 1'b0;
    logic [7:0]  pre_addr = '0;
    logic [12:0] pre_data = '0;
    logic [12:0] in_data = '0;
    logic        in_req;
    logic [12:0] out_data;
    logic        out_valid;
    logic [3:0]  phase;
    logic        halted;

    always #2 clk = ~clk;

    dacc_core uut (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .in_data(in_data), .in_req(in_req),
        .out_data(out_data), .out_valid(out_valid), .phase(phase),
        .halted(halted)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [12:0] got [8];
    int n_out, n_in, halt_k, phase_bad, freeze_bad;

    typedef struct packed {
        logic [3:0]  op;
        logic [12:0] a;
        logic [12:0] b;
        logic [12:0] exp;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{4'h2, 13'h0500, 13'h0101, 13'h0601},
        '{4'h2, 13'h0599, 13'h0120, 13'h0719},
        '{4'h2, 13'h0999, 13'h0001, 13'h1000},
        '{4'h2, 13'h0055, 13'h0045, 13'h0100},
        '{4'h2, 13'h1300, 13'h1200, 13'h0500},
        '{4'h7, 13'h0601, 13'h0000, 13'h0601},
        '{4'h7, 13'h0100, 13'h0001, 13'h0099},
        '{4'h7, 13'h0000, 13'h0001, 13'h1999},
        '{4'h7, 13'h0250, 13'h0750, 13'h1500},
        '{4'h1, 13'h0123, 13'h1234, 13'h1234}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic check_eq(input string req, input string what,
                            input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd2(input int i);
        return {4'(i / 10), 4'(i % 10)};
    endfunction

    task automatic poke(input logic [7:0] a, input logic [12:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
    endtask

    // hold reset and fill every location with a no-op word
    task automatic wipe();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 100; i++) poke(bcd2(i), 13'h0300);
    endtask

    task automatic run_prog(input logic [12:0] din, input int limit);
        @(negedge clk);
        pre_we = 1'b0; in_data = din; rst = 1'b0;
        n_out = 0; n_in = 0; halt_k = -1; phase_bad = 0; freeze_bad = 0;
        for (int k = 0; k < limit; k++) begin
            if (halt_k < 0 && halted) halt_k = k;
            if (halt_k < 0) begin
                if (phase != (4'b0001 << (k % 4))) phase_bad++;
                if (out_valid && n_out < 8) begin
                    got[n_out] = out_data;
                    n_out++;
                end
                if (in_req) n_in++;
            end else begin
                if (phase != 4'b1000 || out_valid || in_req || !halted) freeze_bad++;
                if (k >= halt_k + 12) break;
            end
            @(negedge clk);
        end
        rst = 1'b1;
    endtask

    function automatic string tag_of(input logic [3:0] op);
        return (op == 4'h2) ? "R5" : (op == 4'h7) ? "R6" : "R4";
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1", "phase in reset", phase, 4'b0001);
        check_eq("R1", "out_valid in reset", out_valid, 0);
        check_eq("R1", "halted in reset", halted, 0);
        check_eq("R1", "in_req in reset", in_req, 0);

        // table of arithmetic / load vectors, each run as a short program
        foreach (VECS[i]) begin
            wipe();
            poke(8'h00, 13'h0110);
            poke(8'h01, {1'b0, VECS[i].op, 8'h11});
            poke(8'h02, 13'h0612);
            poke(8'h03, 13'h0512);
            poke(8'h04, 13'h0900);
            poke(8'h10, VECS[i].a);
            poke(8'h11, VECS[i].b);
            poke(8'h12, 13'h0777);
            run_prog(13'h0000, 400);
            check_eq(tag_of(VECS[i].op), $sformatf("vec%0d output count R7", i), n_out, 1);
            check_eq(tag_of(VECS[i].op), $sformatf("vec%0d stored result R9", i), got[0], VECS[i].exp);
            check_eq("R2", $sformatf("vec%0d halt sample", i), halt_k, 19);
            check_eq("R2", $sformatf("vec%0d phase ring", i), phase_bad, 0);
            check_eq("R11", $sformatf("vec%0d frozen after halt", i), freeze_bad, 0);
            if (i == 0) begin
                @(negedge clk);
                check_eq("R1", "halted cleared by reset", halted, 0);
                check_eq("R1", "phase restored by reset", phase, 4'b0001);
            end
        end

        // directed: mixed program with input, store, no-op and jump link
        wipe();
        poke(8'h00, 13'h0120);
        poke(8'h01, 13'h0500);
        poke(8'h02, 13'h0033);
        poke(8'h03, 13'h0533);
        poke(8'h04, 13'h0200);
        poke(8'h05, 13'h0733);
        poke(8'h06, 13'h0610);
        poke(8'h07, 13'h0310);
        poke(8'h08, 13'h0510);
        poke(8'h09, 13'h0840);
        poke(8'h20, 13'h0599);
        poke(8'h40, 13'h0599);
        poke(8'h41, 13'h0900);
        run_prog(13'h0005, 600);
        check_eq("R7", "mixed output count", n_out, 4);
        check_eq("R4", "load from operand, not next word", got[0], 13'h0120);
        check_eq("R8", "input word written then read", got[1], 13'h0005);
        check_eq("R12", "acc/store unchanged across no-op (599+120-5)", got[2], 13'h0714);
        check_eq("R10", "link word at 99", got[3], 13'h0010);
        check_eq("R8", "in_req pulses", n_in, 1);
        check_eq("R2", "mixed halt sample", halt_k, 47);
        check_eq("R11", "mixed frozen after halt", freeze_bad, 0);

        // directed: counter wraps 99 -> 00 after the link word runs as an input
        wipe();
        poke(8'h00, 13'h0896);
        poke(8'h96, 13'h0599);
        poke(8'h97, 13'h0180);
        poke(8'h98, 13'h0600);
        poke(8'h80, 13'h0900);
        run_prog(13'h0042, 400);
        check_eq("R10", "link word 001", got[0], 13'h0001);
        check_eq("R3", "wrap output count", n_out, 1);
        check_eq("R8", "link executed as input", n_in, 1);
        check_eq("R3", "halt reached at 00 after wrap", halt_k, 23);
        check_eq("R2", "wrap phase ring", phase_bad, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule